// File: doc/BRIEF.md
# Storage Fault Status Encoder

This block turns the result of an address translation fault into the actions that enter an exception. A one-cycle strobe presents the fault class, the kind of access, a store flag, the faulting address, the current program counter and the current status word. One clock later the block presents a registered exception entry: the exception number and handler address, the saved return PC and status word, and the updated data fault status and data fault address registers. It also pulses a flush request so that cached translations are dropped.

Code fetch faults select the instruction storage exception. Data faults select the data storage exception, except that a floating-point access to a direct-store segment is redirected to the alignment exception. For data storage exceptions the status register is cleared and rebuilt from the fault class, the access kind and the store flag. The strobe is a plain control pin with no back-pressure: a strobe is accepted on every cycle it is high, and each one produces its own one-cycle entry pulse. The consumer must take the entry in the cycle it is shown.

Top module: `storage_fault_encoder`

## Requirements
- R1: After reset all registered outputs are zero and `entry_valid` and `xlat_flush` are low.
- R2: A data fault (access kind not 0) of class 0 (no match) gives exception number 3 and a status value containing bit 30; class 1 (protection) or class 2 (no-execute) gives exception number 3 and bit 27.
- R3: A store data fault that raises exception 3 also sets bit 25. Every data-side exception (numbers 3 and 6) loads the faulting address into `dfault_addr`.
- R4: A data fault of class 3 (direct-store) with access kind 1 (integer), 3 (reserve/conditional) or 4 (external control) gives exception 3 with bits 31 and 26. Kind 4 also sets bit 20.
- R5: A data fault of class 3 with access kind 2 (floating point) gives exception number 6 (alignment). `dfault_status` is left unchanged, and `dfault_addr` is loaded.
- R6: Data class 4 (breakpoint match) sets bit 22. Data class 5 (external-control cause) sets bit 20. Both give exception 3.
- R7: Access kind 0 (code fetch) gives exception number 4 for any class and store flag. `dfault_status` and `dfault_addr` are left unchanged.
- R8: On each exception 3 the status register holds only the bits of the new fault; no bit of an earlier fault survives.
- R9: One cycle after a strobe, `entry_valid` is high for exactly one cycle. `handler_addr` equals the exception number shifted left by 8, `save_pc` equals the strobed PC, and `save_status` equals the strobed status word.
- R10: `xlat_flush` pulses in the same cycle as `entry_valid`.
- R11: In a cycle without a strobe, every saved register holds its value and no entry pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | One-cycle fault strobe |
| fault_class | input | 3 | 0 no match, 1 protection, 2 no-execute, 3 direct-store, 4 breakpoint, 5 external control |
| access_kind | input | 3 | 0 code, 1 integer, 2 floating point, 3 reserve/conditional, 4 external control |
| access_store | input | 1 | Access was a store |
| fault_addr | input | AW | Faulting effective address |
| cur_pc | input | AW | PC to return to |
| cur_status | input | SW | Status word before entry |
| entry_valid | output | 1 | Exception entry pulse |
| exc_num | output | EXC_W | Selected exception number |
| handler_addr | output | AW | Handler vector |
| save_pc | output | AW | Saved return PC |
| save_status | output | SW | Saved status word |
| dfault_status | output | 32 | Data fault status register |
| dfault_addr | output | AW | Data fault address register |
| xlat_flush | output | 1 | Translation invalidate pulse |

## Verification
Random faults draw every class, access kind and store value with random addresses, PCs and status words. Each one is compared against a bench model of the exception number, the status bits and which registers may change, so a wrong bit position or a missing clear shows up. Directed cases follow one data fault with another and then with a code fetch fault. These separate a register that is cleared on each data fault from one that accumulates bits, and a status register that code faults leave alone from one they corrupt. The floating-point and reserve direct-store cases separate the alignment redirect from the unsupported-access path. Idle gaps between strobes show that the entry pulse lasts one cycle and that the saved values hold.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [2:0] {
    FC_NOMATCH = 3'd0,
    FC_PROT    = 3'd1,
    FC_NOEXEC  = 3'd2,
    FC_DIRECT  = 3'd3,
    FC_BKPT    = 3'd4,
    FC_EXTCTL  = 3'd5
  } fault_class_e;

  typedef enum logic [2:0] {
    AK_CODE  = 3'd0,
    AK_INT   = 3'd1,
    AK_FLOAT = 3'd2,
    AK_RESV  = 3'd3,
    AK_EXT   = 3'd4
  } access_kind_e;

  typedef enum logic [1:0] {
    XS_INSTR = 2'd0,
    XS_DATA  = 2'd1,
    XS_ALIGN = 2'd2
  } exc_sel_e;

  localparam int unsigned ST_UNSUP   = 31;
  localparam int unsigned ST_NOMATCH = 30;
  localparam int unsigned ST_PROT    = 27;
  localparam int unsigned ST_DSTORE  = 26;
  localparam int unsigned ST_STORE   = 25;
  localparam int unsigned ST_BKPT    = 22;
  localparam int unsigned ST_EXTCTL  = 20;
endpackage

// File: rtl/sfe_classify.sv
module sfe_classify
  import sfe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fault_valid,
  input  logic [2:0] fault_class,
  input  logic [2:0] access_kind,
  output exc_sel_e sel,
  output logic     data_side,
  output logic     upd_status
);
  fault_class_e cls;
  access_kind_e kind;

  always_comb begin
    cls  = fault_class_e'(fault_class);
    kind = access_kind_e'(access_kind);
    if (kind == AK_CODE)
      sel = XS_INSTR;
    else if (cls == FC_DIRECT && kind == AK_FLOAT)
      sel = XS_ALIGN;
    else
      sel = XS_DATA;
    data_side  = (sel != XS_INSTR);
    upd_status = (sel == XS_DATA);
  end

  p_fp_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_class == 3'd3 && access_kind == 3'd2) |-> (sel == XS_ALIGN && !upd_status));

  p_code_instr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && access_kind == 3'd0) |-> (sel == XS_INSTR && !data_side));
endmodule

// File: rtl/sfe_cause.sv
module sfe_cause
  import sfe_pkg::*;
(
  input  logic [2:0]  fault_class,
  input  logic [2:0]  access_kind,
  input  logic        access_store,
  output logic [31:0] status_word
);
  fault_class_e cls;
  access_kind_e kind;

  always_comb begin
    cls  = fault_class_e'(fault_class);
    kind = access_kind_e'(access_kind);
    status_word = '0;
    unique case (cls)
      FC_PROT, FC_NOEXEC: status_word[ST_PROT] = 1'b1;
      FC_DIRECT: begin
        status_word[ST_UNSUP]  = 1'b1;
        status_word[ST_DSTORE] = 1'b1;
        if (kind == AK_EXT) status_word[ST_EXTCTL] = 1'b1;
      end
      FC_BKPT:   status_word[ST_BKPT]   = 1'b1;
      FC_EXTCTL: status_word[ST_EXTCTL] = 1'b1;
      default:   status_word[ST_NOMATCH] = 1'b1;
    endcase
    if (access_store) status_word[ST_STORE] = 1'b1;
  end
endmodule

// File: rtl/sfe_regs.sv
module sfe_regs
  import sfe_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned SW        = 32,
  parameter int unsigned EXC_W     = 8,
  parameter int unsigned VEC_SHIFT = 8,
  parameter int unsigned NUM_DATA  = 3,
  parameter int unsigned NUM_INSTR = 4,
  parameter int unsigned NUM_ALIGN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_valid,
  input  exc_sel_e         sel,
  input  logic             data_side,
  input  logic             upd_status,
  input  logic [31:0]      status_word,
  input  logic [AW-1:0]    fault_addr,
  input  logic [AW-1:0]    cur_pc,
  input  logic [SW-1:0]    cur_status,
  output logic             entry_valid,
  output logic [EXC_W-1:0] exc_num,
  output logic [AW-1:0]    handler_addr,
  output logic [AW-1:0]    save_pc,
  output logic [SW-1:0]    save_status,
  output logic [31:0]      dfault_status,
  output logic [AW-1:0]    dfault_addr,
  output logic             xlat_flush
);
  localparam int unsigned PAD_W = AW - EXC_W;

  logic [EXC_W-1:0] num_next;
  logic [AW-1:0]    vec_next;

  always_comb begin
    unique case (sel)
      XS_INSTR: num_next = EXC_W'(NUM_INSTR);
      XS_ALIGN: num_next = EXC_W'(NUM_ALIGN);
      default:  num_next = EXC_W'(NUM_DATA);
    endcase
    vec_next = {{PAD_W{1'b0}}, num_next} << VEC_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_valid   <= 1'b0;
      xlat_flush    <= 1'b0;
      exc_num       <= '0;
      handler_addr  <= '0;
      save_pc       <= '0;
      save_status   <= '0;
      dfault_status <= '0;
      dfault_addr   <= '0;
    end else begin
      entry_valid <= fault_valid;
      xlat_flush  <= fault_valid;
      if (fault_valid) begin
        exc_num      <= num_next;
        handler_addr <= vec_next;
        save_pc      <= cur_pc;
        save_status  <= cur_status;
        if (data_side)  dfault_addr   <= fault_addr;
        if (upd_status) dfault_status <= status_word;
      end
    end
  end

  p_flush_with_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid == xlat_flush);

  p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> handler_addr == ({{PAD_W{1'b0}}, exc_num} << VEC_SHIFT));

  p_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (entry_valid && save_pc == $past(cur_pc) && save_status == $past(cur_status)));

  p_instr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && sel == XS_INSTR) |=> ($stable(dfault_status) && $stable(dfault_addr)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> (!entry_valid && $stable(save_pc) && $stable(dfault_status) && $stable(dfault_addr)));

  p_data_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && upd_status) |=> dfault_status != 32'd0);
endmodule

// File: rtl/storage_fault_encoder.sv
module storage_fault_encoder
  import sfe_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned SW        = 32,
  parameter int unsigned EXC_W     = 8,
  parameter int unsigned VEC_SHIFT = 8,
  parameter int unsigned NUM_DATA  = 3,
  parameter int unsigned NUM_INSTR = 4,
  parameter int unsigned NUM_ALIGN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_valid,
  input  logic [2:0]       fault_class,
  input  logic [2:0]       access_kind,
  input  logic             access_store,
  input  logic [AW-1:0]    fault_addr,
  input  logic [AW-1:0]    cur_pc,
  input  logic [SW-1:0]    cur_status,
  output logic             entry_valid,
  output logic [EXC_W-1:0] exc_num,
  output logic [AW-1:0]    handler_addr,
  output logic [AW-1:0]    save_pc,
  output logic [SW-1:0]    save_status,
  output logic [31:0]      dfault_status,
  output logic [AW-1:0]    dfault_addr,
  output logic             xlat_flush
);
  exc_sel_e    sel;
  logic        data_side;
  logic        upd_status;
  logic [31:0] status_word;

  sfe_classify u_classify (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_valid (fault_valid),
    .fault_class (fault_class),
    .access_kind (access_kind),
    .sel         (sel),
    .data_side   (data_side),
    .upd_status  (upd_status)
  );

  sfe_cause u_cause (
    .fault_class  (fault_class),
    .access_kind  (access_kind),
    .access_store (access_store),
    .status_word  (status_word)
  );

  sfe_regs #(
    .AW(AW), .SW(SW), .EXC_W(EXC_W), .VEC_SHIFT(VEC_SHIFT),
    .NUM_DATA(NUM_DATA), .NUM_INSTR(NUM_INSTR), .NUM_ALIGN(NUM_ALIGN)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_valid   (fault_valid),
    .sel           (sel),
    .data_side     (data_side),
    .upd_status    (upd_status),
    .status_word   (status_word),
    .fault_addr    (fault_addr),
    .cur_pc        (cur_pc),
    .cur_status    (cur_status),
    .entry_valid   (entry_valid),
    .exc_num       (exc_num),
    .handler_addr  (handler_addr),
    .save_pc       (save_pc),
    .save_status   (save_status),
    .dfault_status (dfault_status),
    .dfault_addr   (dfault_addr),
    .xlat_flush    (xlat_flush)
  );

  p_store_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && access_store && access_kind != 3'd0 && !(fault_class == 3'd3 && access_kind == 3'd2))
      |=> dfault_status[25]);

  p_direct_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_class == 3'd3 && access_kind != 3'd0 && access_kind != 3'd2)
      |=> (dfault_status[31] && dfault_status[26] && exc_num == EXC_W'(NUM_DATA)));
endmodule

// File: tb/storage_fault_encoder_bench.sv
`timescale 1ns/1ps
module storage_fault_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_valid = 1'b0;
  logic [2:0]  fault_class = '0;
  logic [2:0]  access_kind = '0;
  logic        access_store = 1'b0;
  logic [31:0] fault_addr = '0, cur_pc = '0, cur_status = '0;
  logic        entry_valid, xlat_flush;
  logic [7:0]  exc_num;
  logic [31:0] handler_addr, save_pc, save_status, dfault_status, dfault_addr;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_dsisr = '0, m_dar = '0;
  int unsigned seed_sink;

  always #2.5 clk = ~clk;

  storage_fault_encoder u_storage_fault_encoder (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_class(fault_class),
    .access_kind(access_kind), .access_store(access_store), .fault_addr(fault_addr),
    .cur_pc(cur_pc), .cur_status(cur_status), .entry_valid(entry_valid),
    .exc_num(exc_num), .handler_addr(handler_addr), .save_pc(save_pc),
    .save_status(save_status), .dfault_status(dfault_status),
    .dfault_addr(dfault_addr), .xlat_flush(xlat_flush));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_num(input logic [2:0] c, input logic [2:0] k);
    if (k == 3'd0) return 8'd4;
    if (c == 3'd3 && k == 3'd2) return 8'd6;
    return 8'd3;
  endfunction

  function automatic logic [31:0] exp_word(input logic [2:0] c, input logic [2:0] k, input logic s);
    logic [31:0] w = '0;
    case (c)
      3'd1, 3'd2: w[27] = 1'b1;
      3'd3: begin w[31] = 1'b1; w[26] = 1'b1; if (k == 3'd4) w[20] = 1'b1; end
      3'd4: w[22] = 1'b1;
      3'd5: w[20] = 1'b1;
      default: w[30] = 1'b1;
    endcase
    if (s) w[25] = 1'b1;
    return w;
  endfunction

  task automatic fault(input logic [2:0] c, input logic [2:0] k, input logic s,
                       input logic [31:0] a, input logic [31:0] pc, input logic [31:0] st);
    logic [7:0] n;
    @(negedge clk);
    fault_valid = 1'b1; fault_class = c; access_kind = k; access_store = s;
    fault_addr = a; cur_pc = pc; cur_status = st;
    n = exp_num(c, k);
    if (n == 8'd3) m_dsisr = exp_word(c, k, s);
    if (n != 8'd4) m_dar = a;
    @(negedge clk);
    fault_valid = 1'b0;
    chk("R9 entry_valid", {31'd0, entry_valid}, 32'd1);
    chk("R10 xlat_flush", {31'd0, xlat_flush}, 32'd1);
    chk(n == 8'd4 ? "R7 exc_num" : (n == 8'd6 ? "R5 exc_num" : "R2 exc_num"), {24'd0, exc_num}, {24'd0, n});
    chk("R9 handler_addr", handler_addr, {16'd0, n, 8'd0});
    chk("R9 save_pc", save_pc, pc);
    chk("R9 save_status", save_status, st);
    chk(n == 8'd3 ? "R8 dfault_status" : "R7 R5 dfault_status kept", dfault_status, m_dsisr);
    chk(n == 8'd4 ? "R7 dfault_addr kept" : "R3 dfault_addr", dfault_addr, m_dar);
  endtask

  task automatic idle_check();
    logic [31:0] pc_before = save_pc;
    @(negedge clk);
    chk("R11 no entry", {31'd0, entry_valid}, 32'd0);
    chk("R11 no flush", {31'd0, xlat_flush}, 32'd0);
    chk("R11 save_pc held", save_pc, pc_before);
    chk("R11 dfault_status held", dfault_status, m_dsisr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 entry_valid", {31'd0, entry_valid}, 32'd0);
    chk("R1 xlat_flush", {31'd0, xlat_flush}, 32'd0);
    chk("R1 dfault_status", dfault_status, 32'd0);
    chk("R1 dfault_addr", dfault_addr, 32'd0);
    chk("R1 save_pc", save_pc, 32'd0);
    chk("R1 handler_addr", handler_addr, 32'd0);

    // directed: R2 no match then protection, R8 clear between
    fault(3'd0, 3'd1, 1'b0, 32'h1000_0040, 32'h0000_2000, 32'h0000_8030);
    chk("R2 nomatch bit30", dfault_status, 32'h4000_0000);
    fault(3'd1, 3'd1, 1'b1, 32'h2000_0080, 32'h0000_2004, 32'h0000_4030);
    chk("R3 R8 prot+store", dfault_status, 32'h0A00_0000);
    // R4 direct-store reserve, external control
    fault(3'd3, 3'd3, 1'b0, 32'h3000_0000, 32'h0000_2008, 32'h1);
    chk("R4 direct reserve", dfault_status, 32'h8400_0000);
    fault(3'd3, 3'd4, 1'b1, 32'h3000_0100, 32'h0000_200C, 32'h2);
    chk("R4 direct extctl store", dfault_status, 32'h8610_0000);
    // R5 floating direct-store -> alignment, status kept
    fault(3'd3, 3'd2, 1'b1, 32'h3000_0200, 32'h0000_2010, 32'h3);
    chk("R5 status kept", dfault_status, 32'h8610_0000);
    chk("R5 addr loaded", dfault_addr, 32'h3000_0200);
    // R6 breakpoint and external-control causes
    fault(3'd4, 3'd1, 1'b0, 32'h4000_0000, 32'h0000_2014, 32'h4);
    chk("R6 breakpoint bit22", dfault_status, 32'h0040_0000);
    fault(3'd5, 3'd1, 1'b0, 32'h4000_0010, 32'h0000_2018, 32'h5);
    chk("R6 extctl bit20", dfault_status, 32'h0010_0000);
    // R7 code fetch keeps data registers
    fault(3'd0, 3'd0, 1'b1, 32'h5000_0000, 32'h0000_201C, 32'h6);
    chk("R7 addr kept", dfault_addr, 32'h4000_0010);
    idle_check();

    // random phase
    for (int i = 0; i < 400; i++) begin
      fault(3'($urandom_range(0, 5)), 3'($urandom_range(0, 4)), 1'($urandom),
            $urandom, $urandom, $urandom);
      if ($urandom_range(0, 3) == 0) idle_check();
    end

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule